// File: doc/BRIEF.md
# Two-Share Masked AND-Shift Gate

This block computes a bitwise AND of two k-bit values while neither value is ever present in the clear. Each operand arrives as a pair of XOR shares. Before the AND, the second operand can be shifted left by a run-time amount. The result leaves the block as a pair of registered XOR shares. The block is the basic step of a masked carry-lookahead adder. Such an adder needs both a plain shifted AND for the propagate terms and a shifted AND followed by an XOR for the generate terms.

The mode select picks one of three behaviours:

- **Plain AND.** Only one fresh random bit is drawn. The remask word is built from the first share of x, moved down one place, with the random bit placed in the top position.
- **AND-XOR with a third operand.** The shares of the third operand take the place of the remask word.
- **Self-XOR.** The unshifted shares of y take the place of the remask word.

Each output share is formed in a fixed order. First the remask term is added to the same-index partial product, and only then the cross-index product. As a result, no intermediate net ever carries both shares of one variable.

Top module: `masked_and_shift`

## Requirements
- R1: In modes 0 and 3, after one accepted input, z0_o ^ z1_o equals (x & (y << shamt)), where x = x0_i ^ x1_i and y = y0_i ^ y1_i.
- R2: In mode 0, each share is exact. With y0s = y0_i << shamt and y1s = y1_i << shamt, and m = (x0_i >> 1) ^ (rnd_i << (k-1)):
  - z0_o = ((x0_i & y0s) ^ m) ^ (x1_i & y0s)
  - z1_o = ((x0_i & y1s) ^ m) ^ (x1_i & y1s)
- R3: In mode 1, each share j gets uj_i in place of m: zj_o = ((x0_i & yjs) ^ uj_i) ^ (x1_i & yjs). The recombined result is (x & (y << shamt)) ^ (u0_i ^ u1_i).
- R4: In mode 2, each share j gets the unshifted yj_i in place of m. The recombined result is (x & (y << shamt)) ^ y.
- R5: The shift is logical left with zero fill. Bits pushed past position k-1 are dropped. shamt = 0 leaves y unshifted. shamt = k-1 keeps only bit 0 of each y share, placed at position k-1.
- R6: valid_o equals valid_i delayed by one clock. The output shares load only on a clock where valid_i is 1, and hold otherwise.
- R7: While rst_ni is low, valid_o, z0_o and z1_o are 0.
- R8: Mode 3 behaves exactly as mode 0.
- R9: In modes 1 and 2, rnd_i has no effect on either output share.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input shares are valid; load result |
| mode_i | input | 2 | 0 plain AND, 1 AND-XOR with u, 2 AND-XOR with unshifted y, 3 as 0 |
| shamt_i | input | log2(k) | Left shift amount applied to the y shares |
| x0_i | input | k | First share of x |
| x1_i | input | k | Second share of x |
| y0_i | input | k | First share of y |
| y1_i | input | k | Second share of y |
| u0_i | input | k | First share of the XOR operand (mode 1) |
| u1_i | input | k | Second share of the XOR operand (mode 1) |
| rnd_i | input | 1 | Fresh random bit for the remask word |
| valid_o | output | 1 | Output shares are valid |
| z0_o | output | k | First result share |
| z1_o | output | k | Second result share |

## Verification
A wrong shift stage or a wrong partial-product bit shows up in the recombined result one clock after the accepted input. It also shows up in both exact shares. A remask term that is wrongly selected or misplaced can cancel out when the two shares are recombined. For that reason the bench compares each share against its exact formula, and such a fault then appears in that same cycle. A faulty load enable shows as a share that changes while valid_i is low, visible on the next clock.

// File: rtl/masked_gate_pkg.sv
package masked_gate_pkg;
  typedef enum logic [1:0] {
    MODE_AND      = 2'd0,
    MODE_AND_XOR  = 2'd1,
    MODE_SELF_XOR = 2'd2,
    MODE_AND_ALT  = 2'd3
  } gate_mode_e;

  localparam int unsigned NUM_SHARES = 2;
endpackage

// File: rtl/share_shifter.sv
module share_shifter #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [SHW-1:0]   shamt_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] stage [SHW+1];

  assign stage[0] = data_i;

  // log2 barrel stages, zero fill
  for (genvar s = 0; s < SHW; s++) begin : g_stage
    assign stage[s+1] = shamt_i[s] ? (stage[s] << (2**s)) : stage[s];
  end

  assign data_o = stage[SHW];
endmodule

// File: rtl/remask_select.sv
module remask_select
  import masked_gate_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  gate_mode_e       mode_i,
  input  logic [WIDTH-1:0] x0_i,
  input  logic             rnd_i,
  input  logic [WIDTH-1:0] u0_i,
  input  logic [WIDTH-1:0] u1_i,
  input  logic [WIDTH-1:0] y0_i,
  input  logic [WIDTH-1:0] y1_i,
  output logic [WIDTH-1:0] add0_o,
  output logic [WIDTH-1:0] add1_o
);
  logic [WIDTH-1:0] guard;

  // shifted x0 share with the fresh bit in the vacated msb
  assign guard = {rnd_i, x0_i[WIDTH-1:1]};

  always_comb begin
    unique case (mode_i)
      MODE_AND_XOR: begin
        add0_o = u0_i;
        add1_o = u1_i;
      end
      MODE_SELF_XOR: begin
        add0_o = y0_i;
        add1_o = y1_i;
      end
      default: begin
        add0_o = guard;
        add1_o = guard;
      end
    endcase
  end
endmodule

// File: rtl/share_combine.sv
module share_combine #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] x0_i,
  input  logic [WIDTH-1:0] x1_i,
  input  logic [WIDTH-1:0] ys0_i,
  input  logic [WIDTH-1:0] ys1_i,
  input  logic [WIDTH-1:0] add0_i,
  input  logic [WIDTH-1:0] add1_i,
  output logic [WIDTH-1:0] z0_o,
  output logic [WIDTH-1:0] z1_o
);
  logic [WIDTH-1:0] ys   [2];
  logic [WIDTH-1:0] add  [2];
  logic [WIDTH-1:0] zq   [2];

  assign ys[0]  = ys0_i;
  assign ys[1]  = ys1_i;
  assign add[0] = add0_i;
  assign add[1] = add1_i;

  for (genvar j = 0; j < 2; j++) begin : g_share
    logic [WIDTH-1:0] same_pp, cross_pp, masked_pp;
    assign same_pp   = x0_i & ys[j];
    assign cross_pp  = x1_i & ys[j];
    // remask before the cross term joins
    assign masked_pp = same_pp ^ add[j];
    assign zq[j]     = masked_pp ^ cross_pp;
  end

  assign z0_o = zq[0];
  assign z1_o = zq[1];
endmodule

// File: rtl/share_reg.sv
module share_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] z0_i,
  input  logic [WIDTH-1:0] z1_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] z0_o,
  output logic [WIDTH-1:0] z1_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      z0_o    <= '0;
      z1_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        z0_o <= z0_i;
        z1_o <= z1_i;
      end
    end
  end

  // R6
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R6
  valid_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(z0_o) && $stable(z1_o)));
endmodule

// File: rtl/masked_and_shift.sv
module masked_and_shift
  import masked_gate_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       mode_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic [WIDTH-1:0] x0_i,
  input  logic [WIDTH-1:0] x1_i,
  input  logic [WIDTH-1:0] y0_i,
  input  logic [WIDTH-1:0] y1_i,
  input  logic [WIDTH-1:0] u0_i,
  input  logic [WIDTH-1:0] u1_i,
  input  logic             rnd_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] z0_o,
  output logic [WIDTH-1:0] z1_o
);
  gate_mode_e       mode;
  logic [WIDTH-1:0] ys0, ys1, add0, add1, zc0, zc1;

  assign mode = gate_mode_e'(mode_i);

  share_shifter #(.WIDTH(WIDTH), .SHW(SHW)) u_shl0 (
    .data_i(y0_i), .shamt_i(shamt_i), .data_o(ys0)
  );
  share_shifter #(.WIDTH(WIDTH), .SHW(SHW)) u_shl1 (
    .data_i(y1_i), .shamt_i(shamt_i), .data_o(ys1)
  );

  remask_select #(.WIDTH(WIDTH)) u_sel (
    .mode_i(mode), .x0_i(x0_i), .rnd_i(rnd_i),
    .u0_i(u0_i), .u1_i(u1_i), .y0_i(y0_i), .y1_i(y1_i),
    .add0_o(add0), .add1_o(add1)
  );

  share_combine #(.WIDTH(WIDTH)) u_comb (
    .x0_i(x0_i), .x1_i(x1_i), .ys0_i(ys0), .ys1_i(ys1),
    .add0_i(add0), .add1_i(add1), .z0_o(zc0), .z1_o(zc1)
  );

  share_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .z0_i(zc0), .z1_i(zc1),
    .valid_o(valid_o), .z0_o(z0_o), .z1_o(z1_o)
  );

  // unmasked reference terms, assertions only
  logic [WIDTH-1:0] plain_and;
  assign plain_and = (x0_i ^ x1_i) & ((y0_i ^ y1_i) << shamt_i);

  // R1
  and_recomb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (mode_i == 2'd0 || mode_i == 2'd3))
      |=> ((z0_o ^ z1_o) == $past(plain_and)));
  // R3
  andxor_recomb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd1)
      |=> ((z0_o ^ z1_o) == $past(plain_and ^ u0_i ^ u1_i)));
  // R4
  selfxor_recomb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd2)
      |=> ((z0_o ^ z1_o) == $past(plain_and ^ y0_i ^ y1_i)));
endmodule

// File: tb/masked_and_shift_tb.sv
module masked_and_shift_tb_top;
  localparam int unsigned W = 32;
  localparam int unsigned SW = $clog2(W);
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0;
  logic [1:0]    mode_i = '0;
  logic [SW-1:0] shamt_i = '0;
  logic [W-1:0]  x0 = '0, x1 = '0, y0 = '0, y1 = '0, u0 = '0, u1 = '0;
  logic          rnd = 1'b0;
  logic          valid_o;
  logic [W-1:0]  z0, z1;

  int unsigned n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  masked_and_shift #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .shamt_i(shamt_i), .x0_i(x0), .x1_i(x1), .y0_i(y0), .y1_i(y1),
    .u0_i(u0), .u1_i(u1), .rnd_i(rnd),
    .valid_o(valid_o), .z0_o(z0), .z1_o(z1)
  );

  function automatic logic [W-1:0] exp_share(input logic [1:0] md, input logic j,
      input logic [W-1:0] a0, a1, b0, b1, c0, c1, input logic r, input logic [SW-1:0] sh);
    logic [W-1:0] yj, addv;
    yj = (j ? b1 : b0) << sh;
    case (md)
      2'd1:    addv = j ? c1 : c0;
      2'd2:    addv = j ? b1 : b0;
      default: addv = (a0 >> 1) ^ ({{(W-1){1'b0}}, r} << (W-1));
    endcase
    return ((a0 & yj) ^ addv) ^ (a1 & yj);
  endfunction

  function automatic logic [W-1:0] exp_plain(input logic [1:0] md,
      input logic [W-1:0] a0, a1, b0, b1, c0, c1, input logic [SW-1:0] sh);
    logic [W-1:0] p;
    p = (a0 ^ a1) & ((b0 ^ b1) << sh);
    case (md)
      2'd1:    return p ^ c0 ^ c1;
      2'd2:    return p ^ b0 ^ b1;
      default: return p;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, result visible one clock later, sampled at next negedge
  task automatic apply(input logic [1:0] md, input logic [SW-1:0] sh,
      input logic [W-1:0] a0, a1, b0, b1, c0, c1, input logic r, input string tag);
    logic [W-1:0] e0, e1, ep;
    mode_i = md; shamt_i = sh; x0 = a0; x1 = a1; y0 = b0; y1 = b1;
    u0 = c0; u1 = c1; rnd = r; valid_i = 1'b1;
    e0 = exp_share(md, 1'b0, a0, a1, b0, b1, c0, c1, r, sh);
    e1 = exp_share(md, 1'b1, a0, a1, b0, b1, c0, c1, r, sh);
    ep = exp_plain(md, a0, a1, b0, b1, c0, c1, sh);
    @(negedge clk);
    valid_i = 1'b0;
    check(valid_o == 1'b1, {tag, " R6 valid_o"}, W'(valid_o), W'(1));
    check(z0 == e0, {tag, " share0"}, z0, e0);
    check(z1 == e1, {tag, " share1"}, z1, e1);
    check((z0 ^ z1) == ep, {tag, " recombined"}, z0 ^ z1, ep);
  endtask

  initial begin
    logic [W-1:0] h0, h1, a, b;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R7 valid_o in reset", W'(valid_o), W'(0));
    check(z0 == '0 && z1 == '0, "R7 shares in reset", z0 | z1, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    apply(2'd0, '0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h0, '0, '0, 1'b1, "R2 R5 shamt0 ones");
    apply(2'd0, SW'(W-1), 32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_0001, 32'h0000_0000, '0, '0, 1'b0, "R5 shamt max");
    check(((z0 ^ z1) & 32'h7FFF_FFFF) == '0, "R5 low bits zero", z0 ^ z1, '0);
    apply(2'd0, 5'd4, 32'hA5A5_A5A5, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 32'hFFFF_0000, '0, '0, 1'b1, "R1 R2 shift4");
    apply(2'd3, 5'd4, 32'hA5A5_A5A5, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 32'hFFFF_0000, '0, '0, 1'b1, "R8 mode3");
    apply(2'd1, 5'd1, 32'h1357_9BDF, 32'h2468_ACE0, 32'h8000_0001, 32'h7FFF_FFFF, 32'hDEAD_BEEF, 32'h0BAD_F00D, 1'b0, "R3 andxor");
    apply(2'd2, 5'd2, 32'hCAFE_BABE, 32'h1111_2222, 32'h3333_4444, 32'h5555_6666, '0, '0, 1'b1, "R4 selfxor");

    // R9: same data, rnd flipped, shares identical
    for (int md = 1; md <= 2; md++) begin
      apply(2'(md), 5'd3, 32'h0123_4567, 32'h89AB_CDEF, 32'hFEDC_BA98, 32'h7654_3210, 32'h1, 32'h2, 1'b0, "R9 rnd0");
      h0 = z0; h1 = z1;
      apply(2'(md), 5'd3, 32'h0123_4567, 32'h89AB_CDEF, 32'hFEDC_BA98, 32'h7654_3210, 32'h1, 32'h2, 1'b1, "R9 rnd1");
      check(z0 == h0 && z1 == h1, "R9 rnd ignored", z0 ^ z1, h0 ^ h1);
    end

    // R6: hold while valid_i low and inputs move
    h0 = z0; h1 = z1;
    x0 = $urandom; y0 = $urandom; rnd = ~rnd;
    @(negedge clk);
    check(valid_o == 1'b0, "R6 valid_o low", W'(valid_o), W'(0));
    check(z0 == h0, "R6 hold share0", z0, h0);
    check(z1 == h1, "R6 hold share1", z1, h1);

    // random mix, R1 R2 R3 R4 R8
    for (int n = 0; n < 400; n++) begin
      a = $urandom; b = $urandom;
      apply(2'($urandom_range(0, 3)), SW'($urandom), a, $urandom, b, $urandom,
            $urandom, $urandom, 1'($urandom), "R1-random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule